// File: doc/BRIEF.md
# Virtual Channel Input Buffer

This unit sits at one input port of a router. Flits arrive on a single physical link, and each one comes with a virtual channel number and a two-bit type. The flit is stored in the queue that belongs to its virtual channel. Each channel keeps its own small state machine. The state machine records whether a packet is being received, and then whether that packet is still waiting to leave after its tail has arrived. This keeps two packets from ever sharing one channel's queue, even when their flits are interleaved on the link.

Every channel's oldest flit is presented at the output, together with its type and the channel state, to the router pipeline downstream. That pipeline removes one flit per cycle by naming a channel on the pop inputs. Each flit removed produces a one-cycle freed pulse carrying the channel number, which upstream credit counters can use. Bad traffic does not corrupt a queue. A write to a full queue, or a flit type that does not fit the channel state, is dropped and latches a sticky flag.

Top module: `vc_input_buffer`

## Requirements
- R1: A flit written with a valid strobe is appended to the queue of the channel named on `in_vc_i`. Each channel presents its oldest flit's data and type, and the flits leave in arrival order.
- R2: The flit type encodings are head 00, body 01, tail 10 and single-flit 11. The channel state encodings are idle 00, receiving 01 and draining 10. A head moves an idle channel to receiving. A single-flit moves an idle channel to draining. A tail moves a receiving channel to draining. A body leaves the state unchanged.
- R3: A legal write to a queue that already holds DEPTH flits is dropped. This holds even when the same queue is popped in that cycle. The drop sets `overflow_o`, which stays set until reset.
- R4: Some writes are illegal. A body or tail is illegal on a channel that is not receiving. A head or single-flit is illegal on a channel that is not idle. An illegal write is dropped, leaves the queue and state unchanged, and sets `proto_err_o`, which stays set until reset. It takes precedence over the overflow check.
- R5: Popping a tail or single-flit returns that channel to idle in the next cycle.
- R6: A pop of a non-empty channel makes `freed_o` high for exactly the next cycle, with `freed_vc_o` equal to the popped channel. A pop of an empty channel is ignored and produces no pulse.
- R7: While reset is held, every queue is empty, every channel is idle, and both flags and `freed_o` are low.
- R8: `out_valid_o` for a channel is high exactly when its queue is non-empty. An idle channel never presents a valid flit.
- R9: Packets on different channels may be interleaved flit by flit on the input link. Each channel still delivers only its own packet's flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming flit strobe |
| in_vc_i | input | VC_W | Channel number of the incoming flit |
| in_type_i | input | 2 | Flit type of the incoming flit |
| in_data_i | input | FLIT_W | Flit payload |
| pop_i | input | 1 | Remove the front flit of the channel on `pop_vc_i` |
| pop_vc_i | input | VC_W | Channel to pop |
| out_valid_o | output | NUM_VC | Per channel: front flit present |
| out_type_o | output | 2*NUM_VC | Per channel: type of the front flit |
| out_data_o | output | FLIT_W*NUM_VC | Per channel: payload of the front flit |
| vc_state_o | output | 2*NUM_VC | Per channel state |
| freed_o | output | 1 | One-cycle pulse for a removed flit |
| freed_vc_o | output | VC_W | Channel of the freed slot |
| overflow_o | output | 1 | Sticky flag: write to a full queue |
| proto_err_o | output | 1 | Sticky flag: flit type illegal for the channel state |

## Verification
The bench builds the unit with four channels, queues of depth four and 16-bit flits. With a queue depth of four, a single five-flit packet sent without pops fills its queue and overflows on the fifth write. That case is combined with a pop in the same cycle. Four channels allow two packets to be interleaved on the link while a third channel is blocked and a fourth stays idle for the protocol-error cases. A long stretch of mixed random traffic then runs, mostly legal with some illegal types, and is compared every cycle against a queue-based model.

// File: rtl/vcib_pkg.sv
package vcib_pkg;
  typedef enum logic [1:0] {
    FLIT_HEAD   = 2'b00,
    FLIT_BODY   = 2'b01,
    FLIT_TAIL   = 2'b10,
    FLIT_SINGLE = 2'b11
  } flit_type_e;

  typedef enum logic [1:0] {
    VC_IDLE  = 2'b00,
    VC_RECV  = 2'b01,
    VC_DRAIN = 2'b10
  } vc_state_e;
endpackage

// File: rtl/vcib_fifo.sv
module vcib_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  assign data_o  = mem[rd_ptr];
  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/vcib_vc_fsm.sv
module vcib_vc_fsm
  import vcib_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  flit_type_e wr_type_i,
  input  logic       full_i,
  input  logic       pop_i,
  input  flit_type_e pop_type_i,
  output logic       accept_o,
  output logic       ovf_o,
  output logic       perr_o,
  output vc_state_e  state_o
);
  vc_state_e state_q, state_d;
  logic      opens, legal;

  assign opens    = (wr_type_i == FLIT_HEAD) || (wr_type_i == FLIT_SINGLE);
  assign legal    = opens ? (state_q == VC_IDLE) : (state_q == VC_RECV);
  assign perr_o   = wr_i && !legal;
  assign ovf_o    = wr_i && legal && full_i;
  assign accept_o = wr_i && legal && !full_i;

  always_comb begin
    state_d = state_q;
    if (pop_i && (pop_type_i == FLIT_TAIL || pop_type_i == FLIT_SINGLE)) begin
      state_d = VC_IDLE;
    end else if (accept_o) begin
      case (wr_type_i)
        FLIT_HEAD:   state_d = VC_RECV;
        FLIT_SINGLE: state_d = VC_DRAIN;
        FLIT_TAIL:   state_d = VC_DRAIN;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= VC_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/vc_input_buffer.sv
module vc_input_buffer
  import vcib_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int FLIT_W = 32,
  localparam int VC_W  = $clog2(NUM_VC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [VC_W-1:0]          in_vc_i,
  input  logic [1:0]               in_type_i,
  input  logic [FLIT_W-1:0]        in_data_i,
  input  logic                     pop_i,
  input  logic [VC_W-1:0]          pop_vc_i,
  output logic [NUM_VC-1:0]        out_valid_o,
  output logic [2*NUM_VC-1:0]      out_type_o,
  output logic [FLIT_W*NUM_VC-1:0] out_data_o,
  output logic [2*NUM_VC-1:0]      vc_state_o,
  output logic                     freed_o,
  output logic [VC_W-1:0]          freed_vc_o,
  output logic                     overflow_o,
  output logic                     proto_err_o
);
  localparam int ENTRY_W = FLIT_W + 2;

  logic [NUM_VC-1:0] wr_sel, push, pop_sel, empty, full, ovf, perr;
  logic [ENTRY_W-1:0] q_head [NUM_VC];

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    vc_state_e st;

    assign wr_sel[g]  = in_valid_i && (in_vc_i == VC_W'(g));
    assign pop_sel[g] = pop_i && (pop_vc_i == VC_W'(g)) && !empty[g];

    vcib_vc_fsm i_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel[g]),
      .wr_type_i  (flit_type_e'(in_type_i)),
      .full_i     (full[g]),
      .pop_i      (pop_sel[g]),
      .pop_type_i (flit_type_e'(q_head[g][FLIT_W +: 2])),
      .accept_o   (push[g]),
      .ovf_o      (ovf[g]),
      .perr_o     (perr[g]),
      .state_o    (st)
    );

    vcib_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[g]),
      .pop_i   (pop_sel[g]),
      .data_i  ({in_type_i, in_data_i}),
      .data_o  (q_head[g]),
      .empty_o (empty[g]),
      .full_o  (full[g])
    );

    assign out_valid_o[g]                = !empty[g];
    assign out_type_o[2*g +: 2]          = q_head[g][FLIT_W +: 2];
    assign out_data_o[FLIT_W*g +: FLIT_W] = q_head[g][FLIT_W-1:0];
    assign vc_state_o[2*g +: 2]          = st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freed_o     <= 1'b0;
      freed_vc_o  <= '0;
      overflow_o  <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      freed_o     <= |pop_sel;
      if (|pop_sel) freed_vc_o <= pop_vc_i;
      overflow_o  <= overflow_o | (|ovf);
      proto_err_o <= proto_err_o | (|perr);
    end
  end
endmodule

// File: rtl/vcib_checker.sv
module vcib_checker
  import vcib_pkg::*;
#(
  parameter int NUM_VC = 4,
  localparam int VC_W  = $clog2(NUM_VC)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic [VC_W-1:0]     in_vc_i,
  input logic [1:0]          in_type_i,
  input logic                pop_i,
  input logic [VC_W-1:0]     pop_vc_i,
  input logic [NUM_VC-1:0]   out_valid_o,
  input logic [2*NUM_VC-1:0] out_type_o,
  input logic [2*NUM_VC-1:0] vc_state_o,
  input logic                freed_o,
  input logic [VC_W-1:0]     freed_vc_o,
  input logic                overflow_o,
  input logic                proto_err_o
);
  assert_overflow_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_proto_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  assert_freed_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && out_valid_o[pop_vc_i]) |=> (freed_o && freed_vc_o == $past(pop_vc_i)));

  assert_no_spurious_freed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && out_valid_o[pop_vc_i]) |=> !freed_o);

  for (genvar g = 0; g < NUM_VC; g++) begin : g_chk
    assert_state_encoding_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vc_state_o[2*g +: 2] != 2'b11);

    assert_head_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_vc_i == VC_W'(g) && in_type_i == FLIT_HEAD &&
       vc_state_o[2*g +: 2] == VC_IDLE) |=> vc_state_o[2*g +: 2] == VC_RECV);

    assert_tail_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && pop_vc_i == VC_W'(g) && out_valid_o[g] && out_type_o[2*g+1])
      |=> vc_state_o[2*g +: 2] == VC_IDLE);

    assert_idle_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vc_state_o[2*g +: 2] == VC_IDLE) |-> !out_valid_o[g]);
  end
endmodule

bind vc_input_buffer vcib_checker #(.NUM_VC(NUM_VC)) i_vcib_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_vc_i     (in_vc_i),
  .in_type_i   (in_type_i),
  .pop_i       (pop_i),
  .pop_vc_i    (pop_vc_i),
  .out_valid_o (out_valid_o),
  .out_type_o  (out_type_o),
  .vc_state_o  (vc_state_o),
  .freed_o     (freed_o),
  .freed_vc_o  (freed_vc_o),
  .overflow_o  (overflow_o),
  .proto_err_o (proto_err_o)
);

// File: tb/test_vc_input_buffer.sv
module test_vc_input_buffer;
  localparam int NV    = 4;
  localparam int DEPTH = 4;
  localparam int FW    = 16;
  localparam int VW    = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni;
  logic              in_valid_i;
  logic [VW-1:0]     in_vc_i;
  logic [1:0]        in_type_i;
  logic [FW-1:0]     in_data_i;
  logic              pop_i;
  logic [VW-1:0]     pop_vc_i;
  logic [NV-1:0]     out_valid_o;
  logic [2*NV-1:0]   out_type_o;
  logic [FW*NV-1:0]  out_data_o;
  logic [2*NV-1:0]   vc_state_o;
  logic              freed_o;
  logic [VW-1:0]     freed_vc_o;
  logic              overflow_o;
  logic              proto_err_o;

  vc_input_buffer #(.NUM_VC(NV), .DEPTH(DEPTH), .FLIT_W(FW)) i_vc_input_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_vc_i(in_vc_i), .in_type_i(in_type_i), .in_data_i(in_data_i),
    .pop_i(pop_i), .pop_vc_i(pop_vc_i),
    .out_valid_o(out_valid_o), .out_type_o(out_type_o), .out_data_o(out_data_o),
    .vc_state_o(vc_state_o), .freed_o(freed_o), .freed_vc_o(freed_vc_o),
    .overflow_o(overflow_o), .proto_err_o(proto_err_o)
  );

  int checks = 0;
  int fails  = 0;

  // reference model: {type, data} per channel
  logic [FW+1:0] mq [NV][$];
  int  mst [NV];
  bit  movf, merr, mfreed;
  int  mfvc;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int v = 0; v < NV; v++) begin
      chk("R8", $sformatf("valid vc%0d", v), out_valid_o[v], mq[v].size() > 0);
      if (mq[v].size() > 0) begin
        chk("R1 R9", $sformatf("data vc%0d", v), out_data_o[v*FW +: FW], mq[v][0][FW-1:0]);
        chk("R1", $sformatf("type vc%0d", v), out_type_o[2*v +: 2], mq[v][0][FW +: 2]);
      end
      chk("R2 R5", $sformatf("state vc%0d", v), vc_state_o[2*v +: 2], mst[v]);
    end
    chk("R3", "overflow", overflow_o, movf);
    chk("R4", "proto_err", proto_err_o, merr);
    chk("R6", "freed", freed_o, mfreed);
    if (mfreed) chk("R6", "freed_vc", freed_vc_o, mfvc);
  endtask

  task automatic step(bit v, int vc, int t, int d, bit p, int pvc);
    bit popping, opens, legal;
    logic [FW+1:0] pf;
    @(negedge clk);
    compare();
    in_valid_i = v;  in_vc_i  = vc[VW-1:0]; in_type_i = t[1:0]; in_data_i = d[FW-1:0];
    pop_i      = p;  pop_vc_i = pvc[VW-1:0];
    popping = p && (mq[pvc].size() > 0);
    pf = '0;
    if (popping) pf = mq[pvc][0];
    if (v) begin
      opens = (t == 0) || (t == 3);
      legal = opens ? (mst[vc] == 0) : (mst[vc] == 1);
      if (!legal) merr = 1'b1;
      else if (mq[vc].size() >= DEPTH) movf = 1'b1;
      else begin
        mq[vc].push_back({t[1:0], d[FW-1:0]});
        if (t == 0) mst[vc] = 1;
        else if (t != 1) mst[vc] = 2;
      end
    end
    if (popping) begin
      void'(mq[pvc].pop_front());
      if (pf[FW+1]) mst[pvc] = 0;  // tail or single leaves
    end
    mfreed = popping;
    mfvc   = pvc;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    in_valid_i = 0; in_vc_i = '0; in_type_i = '0; in_data_i = '0; pop_i = 0; pop_vc_i = '0;
    for (int v = 0; v < NV; v++) mst[v] = 0;
    movf = 0; merr = 0; mfreed = 0; mfvc = 0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7", "valid in reset", out_valid_o, 0);
    chk("R7", "state in reset", vc_state_o, 0);
    chk("R7", "flags in reset", {overflow_o, proto_err_o, freed_o}, 0);
    rst_ni = 1'b1;

    // R2 R5 R6: single-flit packet
    step(1, 0, 3, 'h11, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    idle();

    // R9: two packets interleaved on the link
    step(1, 1, 0, 'h100, 0, 0);
    step(1, 2, 0, 'h200, 0, 0);
    step(1, 1, 1, 'h101, 1, 1);
    step(1, 2, 1, 'h201, 1, 2);
    step(1, 1, 2, 'h102, 1, 1);
    step(1, 2, 2, 'h202, 1, 2);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 2);
    idle();

    // R3: fill vc3, then overflow, once alone and once with a same-cycle pop
    step(1, 3, 0, 'h300, 0, 0);
    for (int i = 1; i < DEPTH; i++) step(1, 3, 1, 'h300 + i, 0, 0);
    step(1, 3, 1, 'h3ee, 0, 0);
    step(1, 3, 1, 'h3ef, 1, 3);
    // R4: head on a receiving channel, body on an idle channel
    step(1, 3, 0, 'h3aa, 0, 0);
    step(1, 0, 1, 'h0bb, 0, 0);
    // R6: pop of an empty channel is ignored
    step(0, 0, 0, 0, 1, 0);
    // drain vc3 and close its packet
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 3);
    step(1, 3, 2, 'h3ff, 0, 0);
    step(0, 0, 0, 0, 1, 3);
    idle();

    // mixed traffic, mostly legal
    for (int i = 0; i < 600; i++) begin
      int vc, t, pvc;
      bit v, p;
      vc = $urandom % NV;
      v  = ($urandom % 4) != 0;
      if (($urandom % 10) == 0)  t = $urandom % 4;
      else if (mst[vc] == 0)     t = (($urandom % 2) != 0) ? 0 : 3;
      else                       t = (($urandom % 3) == 0) ? 2 : 1;
      p   = ($urandom % 2) != 0;
      pvc = $urandom % NV;
      step(v, vc, t, $urandom % 65536, p, pvc);
    end
    for (int i = 0; i < 4 * DEPTH; i++) step(0, 0, 0, 0, 1, i % NV);
    @(negedge clk);
    compare();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule